// File: doc/BRIEF.md
# Coprocessor Instruction Decode and Execute Unit

This unit accepts one coprocessor instruction per clock. The instruction is placed left-aligned on a 64-bit word, and a 2-bit tag gives its length: 16, 32, 48 or 64 bits. A single decoder recognises every supported encoding. It then carries out the instruction against three register sets:

- an internal file of 32 data registers, each 64 bits wide;
- an internal file of 64 control registers, each 32 bits wide;
- the core's 16-entry, 32-bit general register file, reached through a read port and a write port.

The move instructions come in several kinds. A general register can be moved into a data register with zero extension. A general register can also be inserted into the upper half of a data register, leaving the lower half as it was. The low word or the high word of a data register can be copied into a general register. A general register can be written to a control register, and a control register can be read back into a general register. The nops and helper instructions change no state. One 48-bit helper raises a coprocessor exception when its first immediate is zero. Any encoding that matches none of the defined patterns is flagged as illegal.

The core drives `gprRdData` from its register file in the same cycle, using the index the unit presents on `gprRdIdx`. The core commits `gprWrData` into its file at the clock edge that ends any cycle in which `gprWrEn` is high. Writes to the internal files also land at that edge, so the instruction in the next cycle already sees the new value.

Top module: `cop_exec_unit`

## Requirements
- R1: Bits are numbered from the MSB of `instWord`, so bit i is `instWord[63-i]`. The top four bits (0-3) are the major opcode. `instLen` encodes the length as 0 = 16 bits, 1 = 32 bits, 2 = 48 bits and 3 = 64 bits. Bits beyond the tagged length are ignored, and the same word decodes differently under a different tag.
- R2: The following encodings leave all state unchanged and raise no flag:
  - the 16-bit nop: opcode 0, bits 4-15 zero;
  - the 32-bit nop: opcode F, bits 12-15 = 7, all other fields zero;
  - the 32-bit immediate form: as the nop, but bits 21-23 = 1 and any value in bits 24-31;
  - the 48-bit nop: opcode 5, bits 4-15 zero;
  - the 64-bit forms with select 0 or select 7.
- R3: A 16-bit opcode 1 with bits 9-10 zero copies data register [bits 4-8] from data register [bits 11-15].
- R4: A 16-bit opcode 2 with bits 9-11 zero writes the general register [bits 12-15], zero-extended, into data register [bits 4-8]. Opcode 3 with the same zero field writes the low word of data register [bits 4-8] into general register [bits 12-15].
- R5: The 48-bit helper (opcode 4, bits 4-15 zero) raises `copException` in its own issue cycle when bits 16-31 are zero. The exception issues no write of any kind. With a non-zero first immediate, the helper has no effect.
- R6: The 64-bit form has opcode F, bits 4-11 zero, bits 12-15 = 7, bits 16-23 zero and a select in bits 24-31. For selects 1 to 4, bits 32-36 index a data register and bits 37-40 index a general register. Select 1 writes the general register, zero-extended, into the data register. Select 2 writes the data register's low word into the general register.
- R7: Select 3 places the general register in the upper 32 bits of the data register and keeps the lower 32 bits. Select 4 writes the data register's upper word into the general register.
- R8: For selects 5 and 6, bits 32-35 index a control register and bits 36-39 index a general register. Select 5 writes the general register into the control register. Select 6 writes the control register into the general register. The immediate in bits 40-63, and for selects 1 to 4 the immediate in bits 41-63, has no effect.
- R9: Any valid instruction that matches none of the patterns above raises `illegalInst` for that cycle and writes nothing. This includes encodings with a non-zero unused field.
- R10: Reset clears both internal files to zero. A write lands at the edge that ends its issue cycle and is visible to the next instruction. With `instValid` low, the unit writes nothing and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset that clears both internal files |
| instValid | input | 1 | An instruction is present this cycle |
| instLen | input | 2 | Length tag: 0 = 16, 1 = 32, 2 = 48, 3 = 64 bits |
| instWord | input | 64 | Instruction, left-aligned |
| gprRdIdx | output | 4 | Index of the general register to read |
| gprRdData | input | 32 | Value of the general register named by gprRdIdx |
| gprWrEn | output | 1 | Write the general register this cycle |
| gprWrIdx | output | 4 | Index of the general register to write |
| gprWrData | output | 32 | Value to write to the general register |
| copException | output | 1 | Coprocessor exception, asserted in the issue cycle |
| illegalInst | output | 1 | Unrecognised encoding, asserted in the issue cycle |

## Verification
The assertions check two things on every cycle. First, the control strobes are mutually exclusive, so an illegal or excepting instruction never carries a write and an idle cycle does nothing. Second, every internal file write shows up at the addressed entry one cycle later. The bench scenarios are what show the data paths themselves: the choice of register fields, zero extension, the high-half insert that keeps the low half, and the low-word and high-word selection. They also show that bits beyond the tagged length are ignored and that an illegal encoding leaves a previously written register intact.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int INST_W    = 64;
  localparam int CR_IDX_W  = 5;
  localparam int CTL_IDX_W = 6;
  localparam int GPR_IDX_W = 4;
  localparam int CR_W      = 64;
  localparam int GPR_W     = 32;

  typedef enum logic [1:0] {LEN16 = 2'd0, LEN32 = 2'd1, LEN48 = 2'd2, LEN64 = 2'd3} instLen_e;
  typedef enum logic [1:0] {CRSRC_CR = 2'd0, CRSRC_GPRZX = 2'd1, CRSRC_GPRHI = 2'd2} crSrc_e;
  typedef enum logic [1:0] {GSRC_CRLO = 2'd0, GSRC_CRHI = 2'd1, GSRC_CTL = 2'd2} gprSrc_e;

  typedef struct packed {
    logic                 crWr;
    logic [CR_IDX_W-1:0]  crWrIdx;
    logic [CR_IDX_W-1:0]  crRdIdx;
    crSrc_e               crSrc;
    logic                 ctlWr;
    logic [CTL_IDX_W-1:0] ctlIdx;
    logic                 gprWr;
    gprSrc_e              gprSrc;
    logic [GPR_IDX_W-1:0] gprIdx;
    logic                 exc;
    logic                 illegal;
  } copStrobe_t;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  instLen_e          instLen,
  input  logic [INST_W-1:0] instWord,
  output copStrobe_t        st
);
  // Field extraction with MSB-first numbering: start bit s, width n.
  function automatic logic [31:0] fld(input logic [INST_W-1:0] w, input int s, input int n);
    logic [INST_W-1:0] sh;
    sh = w >> (INST_W - s - n);
    return 32'(sh & ((64'd1 << n) - 64'd1));
  endfunction

  logic [3:0]  opc;
  logic [31:0] rest16, uu2, uu3, dst16, src16, gpr16;
  logic [31:0] cr32m, seg32, alone, seg32a, code8, uu12, immA;
  logic [31:0] uu8, uu8a, sel64, crN, gprM, ctlN, ctlG;
  logic        legal;

  always_comb begin
    opc    = fld(instWord, 0, 4)[3:0];
    rest16 = fld(instWord, 4, 12);
    dst16  = fld(instWord, 4, 5);
    uu2    = fld(instWord, 9, 2);
    uu3    = fld(instWord, 9, 3);
    src16  = fld(instWord, 11, 5);
    gpr16  = fld(instWord, 12, 4);
    seg32  = fld(instWord, 9, 3);
    alone  = fld(instWord, 12, 4);
    cr32m  = fld(instWord, 16, 5);
    seg32a = fld(instWord, 21, 3);
    code8  = fld(instWord, 24, 8);
    uu12   = fld(instWord, 4, 12);
    immA   = fld(instWord, 16, 16);
    uu8    = fld(instWord, 4, 8);
    uu8a   = fld(instWord, 16, 8);
    sel64  = fld(instWord, 24, 8);
    crN    = fld(instWord, 32, 5);
    gprM   = fld(instWord, 37, 4);
    ctlN   = fld(instWord, 32, 4);
    ctlG   = fld(instWord, 36, 4);
  end

  always_comb begin
    st    = '0;
    legal = 1'b0;
    if (instValid) begin
      unique case (instLen)
        LEN16: begin
          unique case (opc)
            4'h0: legal = (rest16 == 0);
            4'h1: if (uu2 == 0) begin
              legal      = 1'b1;
              st.crWr    = 1'b1;
              st.crWrIdx = dst16[CR_IDX_W-1:0];
              st.crRdIdx = src16[CR_IDX_W-1:0];
              st.crSrc   = CRSRC_CR;
            end
            4'h2: if (uu3 == 0) begin
              legal      = 1'b1;
              st.crWr    = 1'b1;
              st.crWrIdx = dst16[CR_IDX_W-1:0];
              st.crSrc   = CRSRC_GPRZX;
              st.gprIdx  = gpr16[GPR_IDX_W-1:0];
            end
            4'h3: if (uu3 == 0) begin
              legal      = 1'b1;
              st.gprWr   = 1'b1;
              st.gprIdx  = gpr16[GPR_IDX_W-1:0];
              st.crRdIdx = dst16[CR_IDX_W-1:0];
              st.gprSrc  = GSRC_CRLO;
            end
            default: legal = 1'b0;
          endcase
        end
        LEN32: begin
          if (opc == 4'hF && fld(instWord, 4, 5) == 0 && seg32 == 0 &&
              alone == 7 && cr32m == 0)
            legal = (seg32a == 0 && code8 == 0) || (seg32a == 1);
        end
        LEN48: begin
          if (uu12 == 0) begin
            if (opc == 4'h4) begin
              legal  = 1'b1;
              st.exc = (immA == 0);
            end else if (opc == 4'h5) begin
              legal = 1'b1;
            end
          end
        end
        LEN64: begin
          if (opc == 4'hF && uu8 == 0 && alone == 7 && uu8a == 0) begin
            unique case (sel64)
              0, 7: legal = 1'b1;
              1, 3: begin
                legal      = 1'b1;
                st.crWr    = 1'b1;
                st.crWrIdx = crN[CR_IDX_W-1:0];
                st.crRdIdx = crN[CR_IDX_W-1:0];
                st.crSrc   = (sel64 == 1) ? CRSRC_GPRZX : CRSRC_GPRHI;
                st.gprIdx  = gprM[GPR_IDX_W-1:0];
              end
              2, 4: begin
                legal      = 1'b1;
                st.gprWr   = 1'b1;
                st.crRdIdx = crN[CR_IDX_W-1:0];
                st.gprSrc  = (sel64 == 2) ? GSRC_CRLO : GSRC_CRHI;
                st.gprIdx  = gprM[GPR_IDX_W-1:0];
              end
              5, 6: begin
                legal     = 1'b1;
                st.ctlWr  = (sel64 == 5);
                st.gprWr  = (sel64 == 6);
                st.gprSrc = GSRC_CTL;
                st.ctlIdx = CTL_IDX_W'(ctlN);
                st.gprIdx = ctlG[GPR_IDX_W-1:0];
              end
              default: legal = 1'b0;
            endcase
          end
        end
        default: legal = 1'b0;
      endcase
      st.illegal = !legal;
    end
  end

  // R9
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.illegal |-> !(st.crWr || st.ctlWr || st.gprWr || st.exc));
  // R5
  exc_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.exc |-> !(st.crWr || st.ctlWr || st.gprWr));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> $countones({st.crWr, st.ctlWr, st.gprWr, st.exc, st.illegal}) == 0);
  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.crWr, st.ctlWr, st.gprWr, st.exc, st.illegal}));
endmodule

// File: rtl/cop_datapath.sv
module cop_datapath
  import cop_pkg::*;
#(
  parameter int CTL_W = GPR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  copStrobe_t       st,
  input  logic [GPR_W-1:0] gprRdData,
  output logic [GPR_W-1:0] gprWrData
);
  localparam int CR_CNT  = 1 << CR_IDX_W;
  localparam int CTL_CNT = 1 << CTL_IDX_W;
  localparam int LOW_W   = CR_W - GPR_W;

  logic [CR_W-1:0]  crFile  [CR_CNT];
  logic [CTL_W-1:0] ctlFile [CTL_CNT];
  logic [CR_W-1:0]  crRd, crWrData;
  logic [CTL_W-1:0] ctlRd;

  assign crRd  = crFile[st.crRdIdx];
  assign ctlRd = ctlFile[st.ctlIdx];

  always_comb begin
    unique case (st.crSrc)
      CRSRC_GPRZX: crWrData = {{LOW_W{1'b0}}, gprRdData};
      CRSRC_GPRHI: crWrData = {gprRdData, crRd[LOW_W-1:0]};
      default:     crWrData = crRd;
    endcase
  end

  always_comb begin
    unique case (st.gprSrc)
      GSRC_CRHI: gprWrData = crRd[CR_W-1 -: GPR_W];
      GSRC_CTL:  gprWrData = GPR_W'(ctlRd);
      default:   gprWrData = crRd[GPR_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CR_CNT; i++) crFile[i] <= '0;
    end else if (st.crWr) begin
      crFile[st.crWrIdx] <= crWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CTL_CNT; i++) ctlFile[i] <= '0;
    end else if (st.ctlWr) begin
      ctlFile[st.ctlIdx] <= CTL_W'(gprRdData);
    end
  end

  // R10
  cr_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.crWr |=> crFile[$past(st.crWrIdx)] == $past(crWrData));
  // R8
  ctl_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.ctlWr |=> ctlFile[$past(st.ctlIdx)] == $past(CTL_W'(gprRdData)));
endmodule

// File: rtl/cop_exec_unit.sv
module cop_exec_unit
  import cop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [1:0]           instLen,
  input  logic [INST_W-1:0]    instWord,
  output logic [GPR_IDX_W-1:0] gprRdIdx,
  input  logic [GPR_W-1:0]     gprRdData,
  output logic                 gprWrEn,
  output logic [GPR_IDX_W-1:0] gprWrIdx,
  output logic [GPR_W-1:0]     gprWrData,
  output logic                 copException,
  output logic                 illegalInst
);
  copStrobe_t st;

  cop_decode u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instLen  (instLen_e'(instLen)),
    .instWord (instWord),
    .st       (st)
  );

  cop_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .gprRdData(gprRdData),
    .gprWrData(gprWrData)
  );

  assign gprRdIdx     = st.gprIdx;
  assign gprWrIdx     = st.gprIdx;
  assign gprWrEn      = st.gprWr;
  assign copException = st.exc;
  assign illegalInst  = st.illegal;
endmodule

// File: tb/cop_exec_unit_tb_top.sv
module cop_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [1:0]  instLen = 2'd0;
  logic [63:0] instWord = '0;
  logic [3:0]  gprRdIdx, gprWrIdx;
  logic [31:0] gprRdData, gprWrData;
  logic        gprWrEn, copException, illegalInst;
  logic [31:0] gprModel [16];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cop_exec_unit dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instLen(instLen),
    .instWord(instWord), .gprRdIdx(gprRdIdx), .gprRdData(gprRdData),
    .gprWrEn(gprWrEn), .gprWrIdx(gprWrIdx), .gprWrData(gprWrData),
    .copException(copException), .illegalInst(illegalInst)
  );

  assign gprRdData = gprModel[gprRdIdx];
  always @(posedge clk) if (gprWrEn) gprModel[gprWrIdx] <= gprWrData;

  function automatic logic [31:0] gv(input int i);
    return 32'h9000_0000 + 32'(i) * 32'h0101_0101;
  endfunction
  localparam logic [63:0] BASE64 = 64'hF007_0000_0000_0000;
  function automatic logic [63:0] mk64(input int sel, input int cr, input int g, input int imm);
    return BASE64 | (64'(sel) << 32) | (64'(cr) << 27) | (64'(g) << 23) | 64'(imm & 32'h7F_FFFF);
  endfunction
  function automatic logic [63:0] mk64c(input int sel, input int c, input int g, input int imm);
    return BASE64 | (64'(sel) << 32) | (64'(c) << 28) | (64'(g) << 24) | 64'(imm & 32'hFF_FFFF);
  endfunction
  function automatic logic [63:0] mk16(input int opc, input int a, input int b);
    return (64'(opc) << 60) | (64'(a) << 55) | (64'(b) << 48);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] len, input logic [63:0] w);
    @(posedge clk); #1;
    instValid = 1'b1; instLen = len; instWord = w;
    @(negedge clk);
  endtask

  task automatic expWrite(input string tag, input int idx, input logic [31:0] val);
    chk(gprWrEn === 1'b1, tag, 64'(gprWrEn), 64'd1);
    chk(gprWrIdx === 4'(idx), tag, 64'(gprWrIdx), 64'(idx));
    chk(gprWrData === val, tag, 64'(gprWrData), 64'(val));
  endtask

  // Flag table: len, word, exc, illegal, gpr write
  typedef struct packed { logic [1:0] len; logic [63:0] w; logic exc; logic ill; logic wr; } vec_t;
  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{2'd0, 64'h0000_0000_0000_0000, 1'b0, 1'b0, 1'b0},  // R2 16-bit nop
    '{2'd1, 64'hF007_0000_0000_0000, 1'b0, 1'b0, 1'b0},  // R2 32-bit nop
    '{2'd1, 64'hF007_01AB_0000_0000, 1'b0, 1'b0, 1'b0},  // R2 32-bit immediate form
    '{2'd1, 64'hF007_00AB_0000_0000, 1'b0, 1'b1, 1'b0},  // R9 nop with stray imm
    '{2'd2, 64'h4000_0000_1234_0000, 1'b1, 1'b0, 1'b0},  // R5 exception
    '{2'd2, 64'h4000_0005_1234_0000, 1'b0, 1'b0, 1'b0},  // R5 no exception
    '{2'd2, 64'h5000_0003_0004_0000, 1'b0, 1'b0, 1'b0},  // R2 48-bit nop
    '{2'd2, 64'h4010_0001_0000_0000, 1'b0, 1'b1, 1'b0},  // R9 unused field set
    '{2'd3, 64'hF007_0000_0000_0000, 1'b0, 1'b0, 1'b0},  // R2 select 0
    '{2'd3, 64'hF007_0007_FFFF_FFFF, 1'b0, 1'b0, 1'b0},  // R2 select 7
    '{2'd3, 64'hF007_0008_0000_0000, 1'b0, 1'b1, 1'b0},  // R9 select 8
    '{2'd0, 64'hF007_0000_0000_0000, 1'b0, 1'b1, 1'b0},  // R1 opcode F under 16-bit tag
    '{2'd0, 64'h6000_0000_0000_0000, 1'b0, 1'b1, 1'b0},  // R9 opcode 6
    '{2'd0, 64'h1020_0000_0000_0000, 1'b0, 1'b1, 1'b0},  // R9 move with bits 9-10 set
    '{2'd3, 64'hF107_0001_0000_0000, 1'b0, 1'b1, 1'b0}   // R9 bits 4-11 set
  };

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) gprModel[i] = gv(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 idle after reset
    chk(!gprWrEn && !copException && !illegalInst, "R10 idle", 64'({gprWrEn, copException, illegalInst}), 64'd0);
    // R10 reset cleared files
    issue(2'd3, mk64(4, 5, 7, 0));  expWrite("R10 cr hi reset", 7, 32'h0);
    issue(2'd3, mk64(2, 31, 7, 0)); expWrite("R10 cr lo reset", 7, 32'h0);
    issue(2'd3, mk64c(6, 9, 7, 0)); expWrite("R10 ctl reset", 7, 32'h0);

    for (int k = 0; k < NV; k++) begin
      issue(VT[k].len, VT[k].w);
      chk(copException === VT[k].exc, $sformatf("table %0d exc", k), 64'(copException), 64'(VT[k].exc));
      chk(illegalInst === VT[k].ill, $sformatf("table %0d illegal", k), 64'(illegalInst), 64'(VT[k].ill));
      chk(gprWrEn === VT[k].wr, $sformatf("table %0d write", k), 64'(gprWrEn), 64'(VT[k].wr));
    end

    // R6 zero-extend then low and high word
    issue(2'd3, mk64(1, 5, 3, 23'h7F_FFFF)); chk(!gprWrEn && !illegalInst, "R6 sel1 flags", 64'(gprWrEn), 0);
    issue(2'd3, mk64(2, 5, 7, 23'h1234));   expWrite("R6 low word", 7, gv(3));
    issue(2'd3, mk64(4, 5, 8, 0));          expWrite("R6 zero upper", 8, 32'h0);
    // R7 insert high keeps low
    issue(2'd3, mk64(3, 5, 4, 23'h55));
    issue(2'd3, mk64(4, 5, 8, 0));          expWrite("R7 high word", 8, gv(4));
    issue(2'd3, mk64(2, 5, 7, 0));          expWrite("R7 low kept", 7, gv(3));
    // R3 and R1: 16-bit move with trailing bits beyond length
    issue(2'd0, mk16(1, 10, 5) | 64'h0000_FFFF_FFFF_FFFF);
    chk(!illegalInst, "R1 trailing ignored", 64'(illegalInst), 0);
    issue(2'd3, mk64(4, 10, 8, 0));         expWrite("R3 copy high", 8, gv(4));
    issue(2'd3, mk64(2, 10, 7, 0));         expWrite("R3 copy low", 7, gv(3));
    // R4 16-bit GPR moves
    issue(2'd0, mk16(2, 12, 6));
    issue(2'd0, mk16(3, 12, 9));            expWrite("R4 low word to gpr", 9, gv(6));
    issue(2'd3, mk64(4, 12, 8, 0));         expWrite("R4 zero extended", 8, 32'h0);
    // R8 control registers, immediates ignored
    issue(2'd3, mk64c(5, 9, 2, 24'hABCDEF));
    issue(2'd3, mk64c(6, 9, 11, 24'h123456)); expWrite("R8 ctl readback", 11, gv(2));
    issue(2'd3, mk64c(6, 8, 11, 0));        expWrite("R8 neighbour ctl", 11, 32'h0);
    // R9 illegal write attempt leaves register
    issue(2'd3, mk64(3, 5, 9, 0) | 64'h0000_0100_0000_0000);
    chk(illegalInst === 1'b1, "R9 illegal sel3", 64'(illegalInst), 1);
    issue(2'd3, mk64(4, 5, 8, 0));          expWrite("R9 high unchanged", 8, gv(4));
    // R10 invalid instruction does nothing
    @(posedge clk); #1;
    instValid = 1'b0; instWord = mk64(3, 5, 9, 0); instLen = 2'd3;
    @(negedge clk);
    chk(!gprWrEn && !illegalInst, "R10 invalid quiet", 64'({gprWrEn, illegalInst}), 0);
    issue(2'd3, mk64(4, 5, 8, 0));          expWrite("R10 invalid no write", 8, gv(4));
    // R5 exception carries no write
    issue(2'd2, 64'h4000_0000_0000_0000);
    chk(copException === 1'b1 && !gprWrEn, "R5 exception pulse", 64'({copException, gprWrEn}), 64'd2);
    issue(2'd2, 64'h5000_0000_0000_0000);
    chk(copException === 1'b0, "R5 pulse ends", 64'(copException), 0);

    @(posedge clk); #1; instValid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule